// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block is the bus-interface state machine for a 16-bit processor that has a 20-bit address and a bus shared between address and data. The core presents one request at a time on a simple port. A request gives the direction, memory or I/O space, the address, whether the upper byte lane takes part, the write data, a segment code and the interrupt-enable flag. The sequencer accepts the request and runs one bus cycle in clock states. T1 carries the address. T2 turns the bus around. T3 and any wait states carry the data, and T4 ends the cycle. On the following cycle the block returns read data with a one-cycle completion pulse.

The shared lines are modelled as separate output, output-enable and input vectors, and a pad ring combines them into bidirectional pins. The upper four address lines carry the segment and flag status once T1 is over. A peripheral that is not ready holds the data phase open by keeping the ready input low. A bus master that raises the hold input is granted the bus once the running cycle has finished. Splitting a word at an odd address into two byte cycles is left to the requester.

Top module: `adbus_sequencer`

## Requirements
- R1: A request is accepted (`req_accept` high) only while the block is idle and `hold` is low. An accepted request starts T1 at the next clock edge, and every cycle passes through T1, T2, T3 and T4, in that order, with at least these four states.
- R2: `ale` is high only during T1. In T1, `ad_out` carries address bits 15:0 with `ad_oe` high, and `as_out` carries address bits 19:16 for memory cycles and 0000 for I/O cycles.
- R3: On a read, `ad_oe` is low from T2 through T4. On a write, `ad_oe` is high and `ad_out` holds the write data from T2 through T4.
- R4: From T2 through T4, `as_out` bit 3 is 0, bit 2 is the interrupt-enable flag and bits 1:0 are the segment code, all taken when the request was accepted.
- R5: `bhe_n` equals the inverse of `req_upper` from T1 through T4. With address bit 0, the pair (bhe_n, A0) means: 00 a whole word, 01 the upper byte at an odd address, 10 the lower byte at an even address, 11 no byte lane.
- R6: From T1 through T4, `m_io` is 1 for memory cycles and 0 for I/O cycles, and `dt_r` is 1 for writes and 0 for reads.
- R7: `rd_n` (on reads) or `wr_n` (on writes) is low during T2, T3 and every wait state, and high in T1 and T4. The two strobes are never low together.
- R8: `den_n` is low from T2 through T4 on writes and from T3 through T4 on reads, and high otherwise.
- R9: `ready_in` is sampled at the clock edge that ends T3 and at the edge that ends each wait state. Each low sample adds one wait state before T4, so a cycle lasts four clocks plus one clock per low sample.
- R10: `done` is high for exactly the one clock after T4. On a read, `rd_data` then shows the value of `ad_in` at the end of T4. Writes leave `rd_data` unchanged.
- R11: A high `hold` lets a running cycle finish. After T4, or right away when idle, `hlda` goes high with `ad_oe`, `as_oe` and `ctl_oe` low, and no request is accepted. Lowering `hold` returns the block to idle at the next edge.
- R12: A synchronous `rst` ends any cycle. The block returns to idle with `ad_oe` and `as_oe` low, all strobes and `den_n` high, and `hlda` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr | input | 20 | Byte address |
| req_upper | input | 1 | Upper byte lane takes part |
| req_wdata | input | 16 | Write data, already placed on its lanes |
| req_seg | input | 2 | Segment code for status |
| req_iflag | input | 1 | Interrupt-enable flag for status |
| req_accept | output | 1 | Request taken this cycle |
| rd_data | output | 16 | Last read data |
| done | output | 1 | One-cycle completion pulse |
| ready_in | input | 1 | Device ready |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted |
| ad_in | input | 16 | Shared lines, input side |
| ad_out | output | 16 | Shared lines, output side |
| ad_oe | output | 1 | Drive enable for shared lines |
| as_out | output | 4 | Upper address / status lines |
| as_oe | output | 1 | Drive enable for upper lines |
| ctl_oe | output | 1 | Drive enable for control lines |
| ale | output | 1 | Address latch enable |
| m_io | output | 1 | Memory (1) or I/O (0) |
| dt_r | output | 1 | Transmit (1) or receive (0) |
| den_n | output | 1 | Transceiver enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bhe_n | output | 1 | Upper byte enable, active low |

## Verification
All port behaviour is decoded from the state register, so a wrong state shows up within the same clock. A skipped or extra state changes the cycle length seen at `den_n`, the strobes and `done`. A state reached on the wrong branch drives the shared lines in the wrong direction, or drives status where the address belongs. A wrong decision after T4 shows in the clock after T4: `hlda` fails to rise, or a new `ale` appears while the bus should be granted. A wrong captured request field shows in T1 as a bad address or upper nibble, or from T2 on as bad status or write data.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  parameter int unsigned ADDR_W = 20;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned SEG_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_state_e;
endpackage

// File: rtl/adbus_fsm.sv
module adbus_fsm
  import adbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       ready_in,
  input  logic       hold,
  output bus_state_e state,
  output logic       accept
);
  bus_state_e nxt;

  assign accept = (state == ST_IDLE) && !hold;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (hold)           nxt = ST_HOLD;
        else if (req_valid) nxt = ST_T1;
      end
      ST_T1:   nxt = ST_T2;
      ST_T2:   nxt = ST_T3;
      ST_T3,
      ST_TW:   nxt = ready_in ? ST_T4 : ST_TW;
      ST_T4:   nxt = hold ? ST_HOLD : ST_IDLE;
      ST_HOLD: nxt = hold ? ST_HOLD : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/adbus_capture.sv
module adbus_capture
  import adbus_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  bus_state_e    state,
  input  logic          req_write,
  input  logic          req_mem,
  input  logic [AW-1:0] req_addr,
  input  logic          req_upper,
  input  logic [DW-1:0] req_wdata,
  input  logic [SW-1:0] req_seg,
  input  logic          req_iflag,
  input  logic [DW-1:0] ad_in,
  output logic          wr_q,
  output logic          mem_q,
  output logic [AW-1:0] addr_q,
  output logic          upper_q,
  output logic [DW-1:0] wdata_q,
  output logic [SW-1:0] seg_q,
  output logic          iflag_q,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      mem_q   <= 1'b0;
      addr_q  <= '0;
      upper_q <= 1'b0;
      wdata_q <= '0;
      seg_q   <= '0;
      iflag_q <= 1'b0;
    end else if (take) begin
      wr_q    <= req_write;
      mem_q   <= req_mem;
      addr_q  <= req_addr;
      upper_q <= req_upper;
      wdata_q <= req_wdata;
      seg_q   <= req_seg;
      iflag_q <= req_iflag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state == ST_T4);
      if (state == ST_T4 && !wr_q) rd_data <= ad_in;
    end
  end
endmodule

// File: rtl/adbus_drive.sv
module adbus_drive
  import adbus_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 2
) (
  input  bus_state_e       state,
  input  logic             wr_q,
  input  logic             mem_q,
  input  logic [AW-1:0]    addr_q,
  input  logic             upper_q,
  input  logic [DW-1:0]    wdata_q,
  input  logic [SW-1:0]    seg_q,
  input  logic             iflag_q,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] as_out,
  output logic             as_oe,
  output logic             ctl_oe,
  output logic             ale,
  output logic             m_io,
  output logic             dt_r,
  output logic             den_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             bhe_n,
  output logic             hlda
);
  localparam int unsigned HW  = AW - DW;
  localparam int unsigned PAD = HW - SW - 1;

  logic [HW-1:0] status;
  logic          strobe;

  generate
    if (PAD > 0) begin : g_pad
      assign status = {{PAD{1'b0}}, iflag_q, seg_q};
    end else begin : g_nopad
      assign status = {iflag_q, seg_q};
    end
  endgenerate

  always_comb begin
    ad_out = '0;
    ad_oe  = 1'b0;
    as_out = '0;
    as_oe  = 1'b0;
    ctl_oe = 1'b1;
    ale    = 1'b0;
    m_io   = 1'b0;
    dt_r   = 1'b0;
    den_n  = 1'b1;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    bhe_n  = 1'b1;
    hlda   = 1'b0;
    strobe = 1'b0;
    case (state)
      ST_T1: begin
        ad_oe  = 1'b1;
        ad_out = addr_q[DW-1:0];
        as_oe  = 1'b1;
        as_out = mem_q ? addr_q[AW-1:DW] : '0;
        ale    = 1'b1;
        m_io   = mem_q;
        dt_r   = wr_q;
        bhe_n  = ~upper_q;
      end
      ST_T2, ST_T3, ST_TW, ST_T4: begin
        as_oe  = 1'b1;
        as_out = status;
        ad_oe  = wr_q;
        ad_out = wr_q ? wdata_q : '0;
        m_io   = mem_q;
        dt_r   = wr_q;
        bhe_n  = ~upper_q;
        den_n  = (state == ST_T2) ? ~wr_q : 1'b0;
        strobe = (state != ST_T4);
        rd_n   = ~(strobe & ~wr_q);
        wr_n   = ~(strobe & wr_q);
      end
      ST_HOLD: begin
        ctl_oe = 1'b0;
        hlda   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/adbus_sequencer.sv
module adbus_sequencer
  import adbus_pkg::*;
#(
  parameter int unsigned ADDR_BITS = adbus_pkg::ADDR_W,
  parameter int unsigned DATA_BITS = adbus_pkg::DATA_W,
  parameter int unsigned SEG_BITS  = adbus_pkg::SEG_W,
  localparam int unsigned HI_BITS  = ADDR_BITS - DATA_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_mem,
  input  logic [ADDR_BITS-1:0] req_addr,
  input  logic                 req_upper,
  input  logic [DATA_BITS-1:0] req_wdata,
  input  logic [SEG_BITS-1:0]  req_seg,
  input  logic                 req_iflag,
  output logic                 req_accept,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 done,
  input  logic                 ready_in,
  input  logic                 hold,
  output logic                 hlda,
  input  logic [DATA_BITS-1:0] ad_in,
  output logic [DATA_BITS-1:0] ad_out,
  output logic                 ad_oe,
  output logic [HI_BITS-1:0]   as_out,
  output logic                 as_oe,
  output logic                 ctl_oe,
  output logic                 ale,
  output logic                 m_io,
  output logic                 dt_r,
  output logic                 den_n,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic                 bhe_n
);
  bus_state_e                 state;
  logic                       wr_q, mem_q, upper_q, iflag_q;
  logic [ADDR_BITS-1:0]       addr_q;
  logic [DATA_BITS-1:0]       wdata_q;
  logic [SEG_BITS-1:0]        seg_q;

  adbus_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .ready_in (ready_in),
    .hold     (hold),
    .state    (state),
    .accept   (req_accept)
  );

  adbus_capture #(.AW(ADDR_BITS), .DW(DATA_BITS), .SW(SEG_BITS)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .take     (req_accept & req_valid),
    .state    (state),
    .req_write(req_write),
    .req_mem  (req_mem),
    .req_addr (req_addr),
    .req_upper(req_upper),
    .req_wdata(req_wdata),
    .req_seg  (req_seg),
    .req_iflag(req_iflag),
    .ad_in    (ad_in),
    .wr_q     (wr_q),
    .mem_q    (mem_q),
    .addr_q   (addr_q),
    .upper_q  (upper_q),
    .wdata_q  (wdata_q),
    .seg_q    (seg_q),
    .iflag_q  (iflag_q),
    .rd_data  (rd_data),
    .done     (done)
  );

  adbus_drive #(.AW(ADDR_BITS), .DW(DATA_BITS), .SW(SEG_BITS)) u_drv (
    .state  (state),
    .wr_q   (wr_q),
    .mem_q  (mem_q),
    .addr_q (addr_q),
    .upper_q(upper_q),
    .wdata_q(wdata_q),
    .seg_q  (seg_q),
    .iflag_q(iflag_q),
    .ad_out (ad_out),
    .ad_oe  (ad_oe),
    .as_out (as_out),
    .as_oe  (as_oe),
    .ctl_oe (ctl_oe),
    .ale    (ale),
    .m_io   (m_io),
    .dt_r   (dt_r),
    .den_n  (den_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .bhe_n  (bhe_n),
    .hlda   (hlda)
  );
endmodule

// File: rtl/adbus_sequencer_chk.sv
module adbus_sequencer_chk #(
  parameter int unsigned HW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_accept,
  input logic          done,
  input logic          ready_in,
  input logic          hold,
  input logic          hlda,
  input logic          ad_oe,
  input logic [HW-1:0] as_out,
  input logic          as_oe,
  input logic          ctl_oe,
  input logic          ale,
  input logic          m_io,
  input logic          dt_r,
  input logic          den_n,
  input logic          rd_n,
  input logic          wr_n
);
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  assert_ale_drives_R2: assert property (@(posedge clk) disable iff (rst)
    ale |-> (ad_oe && as_oe));
  assert_io_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (ale && !m_io) |-> (as_out == '0));
  assert_read_turnaround_R3: assert property (@(posedge clk) disable iff (rst)
    (ale && !dt_r) |=> !ad_oe);
  assert_status_top_low_R4: assert property (@(posedge clk) disable iff (rst)
    (as_oe && !ale) |-> !as_out[HW-1]);
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  assert_no_strobe_in_t1_R7: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n && den_n));
  assert_wait_extends_R9: assert property (@(posedge clk) disable iff (rst)
    (!den_n && !(rd_n && wr_n) && !ready_in) |=> !(rd_n && wr_n));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_grant_floats_R11: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!ad_oe && !as_oe && !ctl_oe));
  assert_hold_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    hold |-> !req_accept);
endmodule

bind adbus_sequencer adbus_sequencer_chk #(.HW(HI_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_accept(req_accept),
  .done      (done),
  .ready_in  (ready_in),
  .hold      (hold),
  .hlda      (hlda),
  .ad_oe     (ad_oe),
  .as_out    (as_out),
  .as_oe     (as_oe),
  .ctl_oe    (ctl_oe),
  .ale       (ale),
  .m_io      (m_io),
  .dt_r      (dt_r),
  .den_n     (den_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n)
);

// File: tb/adbus_sequencer_tb.sv
module adbus_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_upper = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_seg = '0;
  logic        req_iflag = 1'b0;
  logic        req_accept;
  logic [15:0] rd_data;
  logic        done;
  logic        ready_in = 1'b1, hold = 1'b0;
  logic        hlda;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [3:0]  as_out;
  logic        as_oe, ctl_oe, ale, m_io, dt_r, den_n, rd_n, wr_n, bhe_n;

  int checks = 0;
  int fails  = 0;
  logic [15:0] last_rd = '0;

  always #10 clk = ~clk;

  adbus_sequencer u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mem(req_mem), .req_addr(req_addr), .req_upper(req_upper),
    .req_wdata(req_wdata), .req_seg(req_seg), .req_iflag(req_iflag),
    .req_accept(req_accept), .rd_data(rd_data), .done(done),
    .ready_in(ready_in), .hold(hold), .hlda(hlda), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .as_out(as_out), .as_oe(as_oe),
    .ctl_oe(ctl_oe), .ale(ale), .m_io(m_io), .dt_r(dt_r), .den_n(den_n),
    .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_upper(input bit mem, input logic [19:0] a);
    return mem ? a[19:16] : 4'h0;
  endfunction

  function automatic logic [3:0] exp_status(input bit ifl, input logic [1:0] seg);
    return {1'b0, ifl, seg};
  endfunction

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic run_cycle(input bit wr, input bit mem, input logic [19:0] addr,
                           input bit up, input logic [15:0] wd,
                           input logic [1:0] seg, input bit ifl,
                           input int waits, input bit hold_mid);
    logic [15:0] din;
    din = 16'($urandom);
    req_valid = 1'b1; req_write = wr; req_mem = mem; req_addr = addr;
    req_upper = up; req_wdata = wd; req_seg = seg; req_iflag = ifl;
    ad_in = din; ready_in = 1'b0;
    #1;
    while (!req_accept) begin
      @(negedge clk); #1;
    end
    check("R1", "accept when idle", req_accept, 1);
    for (int k = 0; k <= 3 + waits; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        check("R2", "ale T1", ale, 1);
        check("R2", "ad_oe T1", ad_oe, 1);
        check("R2", "address low", ad_out, addr[15:0]);
        check("R2", "upper lines T1", as_out, exp_upper(mem, addr));
        check("R7", "strobes idle in T1", {rd_n, wr_n, den_n}, 3'b111);
        check("R10", "done low after pulse", done, 0);
      end else begin
        bit strobe;
        strobe = (k <= 2 + waits);
        check("R2", "ale low", ale, 0);
        check("R4", "status", as_out, exp_status(ifl, seg));
        check("R3", "ad_oe direction", ad_oe, wr);
        if (wr) check("R3", "write data", ad_out, wd);
        check("R7", "rd_n", rd_n, !(strobe && !wr));
        check("R7", "wr_n", wr_n, !(strobe && wr));
        check("R8", "den_n", den_n, wr ? 0 : (k >= 2 ? 0 : 1));
        check("R1", "no hlda mid-cycle", hlda, 0);
      end
      check("R5", "bhe_n", bhe_n, !up);
      check("R6", "m_io", m_io, mem);
      check("R6", "dt_r", dt_r, wr);
      if (k == 1 && hold_mid) hold = 1'b1;
      ready_in = (k >= 2 + waits);
    end
    @(negedge clk);
    if (!wr) last_rd = din;
    check("R10", "done pulse", done, 1);
    check("R10", "rd_data", rd_data, last_rd);
    check("R9", "cycle ended after T4", {rd_n, wr_n, den_n}, 3'b111);
    check("R11", "hlda after cycle", hlda, hold_mid);
    if (hold_mid) begin
      check("R11", "float under grant", {ad_oe, as_oe, ctl_oe}, 3'b000);
      check("R11", "no accept under hold", req_accept, 0);
      hold = 1'b0;
      @(negedge clk);
      check("R11", "grant released", hlda, 0);
      check("R11", "control driven again", ctl_oe, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R12", "reset ad_oe", ad_oe, 0);
    check("R12", "reset as_oe", as_oe, 0);
    check("R12", "reset strobes", {rd_n, wr_n, den_n, ale}, 4'b1110);
    check("R12", "reset hlda/done", {hlda, done}, 2'b00);
    check("R12", "reset accept", req_accept, 1);

    // directed corner cases
    run_cycle(0, 1, 20'hFFFF0, 1, 16'h0000, 2'b01, 1, 0, 0); // word read, top of map
    run_cycle(1, 0, 20'hF0741, 1, 16'hAB00, 2'b00, 0, 2, 0); // I/O odd-byte write, upper zeroed
    run_cycle(0, 1, 20'h12344, 0, 16'h0000, 2'b11, 0, 3, 0); // even byte, waits
    run_cycle(1, 1, 20'h00001, 0, 16'h5A5A, 2'b10, 1, 0, 1); // no-lane code, hold mid-cycle
    run_cycle(0, 0, 20'h0ABCD, 1, 16'h0000, 2'b00, 1, 1, 1); // read then grant

    // hold while idle
    hold = 1'b1; req_valid = 1'b1; req_addr = 20'h11110;
    #1 check("R11", "accept blocked", req_accept, 0);
    @(negedge clk);
    check("R11", "hlda from idle", hlda, 1);
    check("R11", "float from idle", {ad_oe, as_oe, ctl_oe}, 3'b000);
    repeat (2) @(negedge clk);
    check("R11", "no ale under grant", ale, 0);
    hold = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    check("R11", "release to idle", {hlda, req_accept}, 2'b01);

    // reset in the middle of a cycle
    req_valid = 1'b1; req_write = 1'b0; req_mem = 1'b1; req_addr = 20'h33330;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    check("R12", "in T2 before reset", rd_n, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12", "mid-cycle reset float", {ad_oe, as_oe}, 2'b00);
    check("R12", "mid-cycle reset strobes", {rd_n, wr_n, den_n}, 3'b111);
    check("R12", "mid-cycle reset done", {done, hlda}, 2'b00);
    check("R12", "mid-cycle reset rd_data", rd_data, 0);
    last_rd = '0;
    check("R1", "idle after reset", req_accept, 1);

    // random traffic
    for (int i = 0; i < 60; i++) begin
      run_cycle(bit'($urandom % 2), bit'($urandom % 2), 20'($urandom),
                bit'($urandom % 2), 16'($urandom), 2'($urandom),
                bit'($urandom % 2), int'($urandom % 4), (i % 7) == 3);
    end
    report();
  end
endmodule